// File: doc/BRIEF.md
# Per-Channel Event Rate Counter

This block keeps one event counter for each input channel, so that the hit rate of every channel can be measured. Each cycle in which a channel's event input is high adds one to that channel's count. The count saturates at its full-scale value and does not wrap.

A host reads the whole bank through a dedicated SPI slave port. That port has only a clock, an active-low chip select and a data output, and it is asynchronous to the counting clock. When chip select goes low, the request is synchronized into the counting domain. On a single counting-clock cycle, every count is then copied into a snapshot row and the live counters are cleared. The host then clocks out the snapshot. Each read therefore returns the number of events seen since the previous read, and the host can divide that number by its own read interval to get a rate.

A small controller in the counting domain sequences the read. It has three states. RD_IDLE waits for a synchronized chip select. RD_GRAB lasts exactly one cycle and performs the capture and clear. RD_BUSY holds the snapshot until chip select is seen released. The transitions are:
- RD_IDLE to RD_GRAB on synchronized select.
- RD_GRAB to RD_BUSY, unconditionally.
- RD_BUSY to RD_IDLE on synchronized release.

Top module: `evt_rate_bank`

## Requirements
- R1: After reset every live count and every snapshot value is zero, so a first read returns all zeros. The data output is 0 whenever chip select is high.
- R2: Each counting-clock cycle in which `evt_i[c]` is high adds exactly one to the count of channel c.
- R3: A count stops at 4095 (all ones, 12 bits). 4094 and 4095 events read back exactly. 4096 or more events read back as 4095.
- R4: A read captures all counts and clears the live counters in the same cycle. Each read therefore returns only the events since the previous read, and a read with no events in between returns zeros.
- R5: Let edge k be the first rising clock edge that samples chip select low. The capture and clear occur at rising edge k+3. An event sampled at edge k+2 belongs to the interval being read. An event sampled at edge k+3 belongs to the next interval.
- R6: The frame is 48 bits: channel 0 first, then channels 1, 2 and 3, each 12 bits with the MSB first. Bit 0 of the frame is driven while chip select is low and before the first SCK rising edge. The output advances to the next bit on each SCK falling edge, so the host samples on rising edges.
- R7: After all 48 bits, the output stays 0 for any further SCK edges until chip select is released.
- R8: The snapshot stays constant for the whole transaction. Events arriving while the frame is shifted do not alter the frame, and they are reported by the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset of the counting domain |
| evt_i | input | NUM_CH | Event input per channel; each high cycle is one event |
| spi_sck | input | 1 | SPI clock from the host |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_miso | output | 1 | SPI serial data to the host |

## Verification
The bench places single events on the clock edges immediately before and at the capture edge. A design that captures one cycle early or late, or that drops the event arriving during the clear, puts those events in the wrong interval.

It drives four channels to 4094, 4095, 4096 and 5000 events. A wrapping counter returns small values for the last two channels, and an off-by-one limit corrupts the first two.

It injects events while a frame is being shifted. A snapshot that is not held changes mid-frame, and a lost clear shows up as stale counts in the next read.

Over-clocking the frame past 48 bits catches an index that wraps into channel 0 instead of idling low.

// File: rtl/evt_rate_pkg.sv
package evt_rate_pkg;
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_GRAB = 2'd1,
        RD_BUSY = 2'd2
    } rd_state_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/evt_chan_counter.sv
module evt_chan_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (clr)                   cnt <= {{(CNT_W-1){1'b0}}, evt};
        else if (evt && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

    // R4
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt <= CNT_W'(1));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/evt_spi_shifter.sv
module evt_spi_shifter #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 12
) (
    input  logic                    spi_sck,
    input  logic                    spi_csn,
    input  logic [NUM_CH*CNT_W-1:0] frame,
    output logic                    spi_miso
);
    localparam int TOTAL = NUM_CH * CNT_W;
    localparam int IDX_W = $clog2(TOTAL + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] pos;

    always_ff @(negedge spi_sck or posedge spi_csn) begin
        if (spi_csn)           idx <= '0;
        else if (idx != LAST)  idx <= idx + 1'b1;
    end

    always_comb begin
        pos = LAST - 1'b1 - idx;
        if (spi_csn || idx == LAST) spi_miso = 1'b0;
        else                        spi_miso = frame[pos];
    end
endmodule

// File: rtl/evt_rate_bank.sv
module evt_rate_bank #(
    parameter int NUM_CH      = 4,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic              spi_sck,
    input  logic              spi_csn,
    output logic              spi_miso
);
    import evt_rate_pkg::*;

    localparam int TOTAL = NUM_CH * CNT_W;

    rd_state_t        state, state_nx;
    logic             sel_sync;
    logic             grab;
    logic [CNT_W-1:0] live [NUM_CH];
    logic [CNT_W-1:0] snap [NUM_CH];
    logic [TOTAL-1:0] frame;

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (~spi_csn),
        .q_sync  (sel_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        grab     = 1'b0;
        unique case (state)
            RD_IDLE: if (sel_sync) state_nx = RD_GRAB;
            RD_GRAB: begin
                grab     = 1'b1;
                state_nx = RD_BUSY;
            end
            RD_BUSY: if (!sel_sync) state_nx = RD_IDLE;
            default: state_nx = RD_IDLE;
        endcase
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        evt_chan_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_i[c]),
            .clr   (grab),
            .cnt   (live[c])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    snap[c] <= '0;
            else if (grab) snap[c] <= live[c];
        end

        assign frame[TOTAL-1-c*CNT_W -: CNT_W] = snap[c];
    end

    evt_spi_shifter #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_shift (
        .spi_sck  (spi_sck),
        .spi_csn  (spi_csn),
        .frame    (frame),
        .spi_miso (spi_miso)
    );

    // R5
    grab_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == RD_GRAB |=> state == RD_BUSY);

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != RD_GRAB |=> $stable(frame));

    // R5
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_IDLE && !sel_sync) |=> state == RD_IDLE);
endmodule

// File: tb/tb_evt_rate_bank.sv
module tb_evt_rate_bank;
    localparam int CLK_PERIOD = 10;
    localparam int SCK_HALF   = 20;
    localparam int NCH        = 4;
    localparam int CW         = 12;
    localparam int NBITS      = NCH * CW;
    localparam int XBITS      = NBITS + 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] evt_i = '0;
    logic           spi_sck = 1'b0;
    logic           spi_csn = 1'b1;
    logic           spi_miso;

    int n_checks = 0;
    int n_fail   = 0;
    int model [NCH];
    logic [NBITS-1:0] exp_q [$];
    logic [NBITS-1:0] act_q [$];
    string            tag_q [$];

    evt_rate_bank #(.NUM_CH(NCH), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_expected(input string tag);
        logic [NBITS-1:0] w;
        for (int c = 0; c < NCH; c++) begin
            w[NBITS-1-c*CW -: CW] = CW'((model[c] > 4095) ? 4095 : model[c]);
            model[c] = 0;
        end
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic run_events(input int n, input int dens);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                evt_i[c] = (($urandom % 100) < dens);
                if (evt_i[c]) model[c]++;
            end
        end
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic shift_frame();
        logic [XBITS-1:0] rx;
        for (int i = 0; i < XBITS; i++) begin
            #SCK_HALF;
            rx[XBITS-1-i] = spi_miso;
            spi_sck = 1'b1;
            #SCK_HALF;
            spi_sck = 1'b0;
        end
        #SCK_HALF;
        chk("R7 tail bits", int'(rx[3:0]), 0);
        act_q.push_back(rx[XBITS-1:4]);
        spi_csn = 1'b1;
        #5;
        chk("R1 idle output", int'(spi_miso), 0);
    endtask

    task automatic read_frame(input string tag, input bit probe, input bit busy);
        @(negedge clk);
        spi_csn = 1'b0;
        if (probe) begin
            @(negedge clk);
            @(negedge clk);
            evt_i = 4'b0010;
            model[1]++;
            push_expected(tag);
            @(negedge clk);
            evt_i = 4'b0100;
            model[2]++;
            @(negedge clk);
            evt_i = '0;
        end else begin
            push_expected(tag);
        end
        repeat (8) @(negedge clk);
        if (busy) begin
            fork
                shift_frame();
                run_events(150, 30);
            join
        end else begin
            shift_frame();
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin : monitor
        logic [NBITS-1:0] a, e;
        string t;
        forever begin
            wait (act_q.size() > 0);
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            for (int c = 0; c < NCH; c++)
                chk($sformatf("%s ch%0d", t, c),
                    int'(a[NBITS-1-c*CW -: CW]), int'(e[NBITS-1-c*CW -: CW]));
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        for (int c = 0; c < NCH; c++) model[c] = 0;
        repeat (5) @(negedge clk);
        chk("R1 output in reset", int'(spi_miso), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        read_frame("R1", 1'b0, 1'b0);
        run_events(300, 20);
        read_frame("R2 R4 R6", 1'b0, 1'b0);
        run_events(500, 50);
        read_frame("R4 R6", 1'b0, 1'b0);
        run_events(200, 10);
        read_frame("R5 capture edge", 1'b1, 1'b0);
        run_events(100, 40);
        read_frame("R8 during shift", 1'b0, 1'b1);
        run_events(50, 40);
        read_frame("R8 next interval", 1'b0, 1'b0);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            evt_i[0] = (i < 4094);
            evt_i[1] = (i < 4095);
            evt_i[2] = 1'b1;
            evt_i[3] = (i < 4096);
            for (int c = 0; c < NCH; c++) if (evt_i[c]) model[c]++;
        end
        @(negedge clk);
        evt_i = '0;
        read_frame("R3 saturation", 1'b0, 1'b0);
        read_frame("R3 R4 cleared", 1'b0, 1'b0);
        wait (act_q.size() == 0);
        #1;
        finish_run();
    end
endmodule